// File: doc/BRIEF.md
# Chained Dual-Access DMA Engine

This block moves a block of data from a source region to a destination region in two phases that overlap: read beats fetch words from the source into an internal holding FIFO, and write beats take words out of the FIFO and store them at the destination. Software sets up each phase as its own buffer descriptor in a 16-entry descriptor table. A descriptor gives a start address, a byte count and an attribute byte. Descriptors are used in pairs. The first descriptor of a pair supplies the read side, and its next field names the write-side partner.

Software writes the channel control, which gives the first descriptor, a bus select and a priority, and sets the activate bit to start the transfer. When both descriptors of a pair have finished, the write descriptor's valid-next flag decides what happens. If the flag is set, the engine loads another pair. If it is clear, the engine closes the channel and raises a sticky done flag. Any descriptor that has its interrupt enable set gives a one-cycle interrupt pulse when its byte count runs out. All memory traffic goes through one request/acknowledge port.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset, `active`, `done`, `irq` and `mem_req` are all low, and no request is made while `active` is low.
- R2: A table write with `tbl_we` high stores address, byte count and attribute at entry `tbl_idx`. The attribute layout is bit 7 valid-next, bits 6:3 next index, bit 2 interrupt enable, bits 1:0 beat size code (0 = 1 byte, 1 = 2 bytes, 2 and 3 = 4 bytes).
- R3: A control write starts the engine only when `ctl_act` is 1 and the engine is idle. A control write with `ctl_act` 0 does not start it. A control write made while the engine is active has no effect on the running transfer.
- R4: A pair is formed from the read descriptor (first, or the next one reached by chaining) and the entry named by its next index. The read descriptor's valid-next bit is ignored.
- R5: Read beats start at the read descriptor's address and advance by the beat size. Their number is the byte count divided by the beat size. Every request carries its descriptor's size code on `mem_size`, and the `mem_bus` and `mem_prio` values from the control write that started the run.
- R6: Write beats start at the write descriptor's address and advance by its beat size. Write beat k carries the data returned by read beat k of the same pair.
- R7: A read is issued whenever read bytes remain and the FIFO holds fewer than 16 words. Otherwise a write is issued if write bytes remain and the FIFO is not empty. For a pair of N beats, the first write is therefore beat number min(N,16), counting from 0.
- R8: Once `mem_req` is raised, it stays high with the same `mem_addr` and `mem_wr` until the cycle in which `mem_ack` is high. A beat is accepted on the clock edge where both are high.
- R9: When both descriptors of a pair have finished and the write descriptor's valid-next bit is set, the entry at its next index starts the next pair, without software action.
- R10: When both descriptors of a pair have finished and the write descriptor's valid-next bit is clear, `active` goes low and `done` goes high on the same edge. `done` stays high until a `done_clr` pulse. If setting and clearing fall on the same edge, setting wins.
- R11: `irq` is high for exactly one cycle after the edge that accepts the final beat of a descriptor whose interrupt enable is set. Descriptors without it give no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Descriptor table write strobe |
| tbl_idx | input | 4 | Descriptor entry to write |
| tbl_addr | input | 32 | Descriptor start address |
| tbl_count | input | 16 | Descriptor byte count |
| tbl_attr | input | 8 | Descriptor attribute byte |
| ctl_we | input | 1 | Channel control write strobe |
| ctl_act | input | 1 | Activate bit |
| ctl_bus | input | 1 | Bus select (0 system, 1 local) |
| ctl_prio | input | 2 | Priority level |
| ctl_first | input | 4 | First descriptor index |
| done_clr | input | 1 | Clears the done flag |
| mem_req | output | 1 | Beat request |
| mem_wr | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Beat address |
| mem_size | output | 2 | Beat size code |
| mem_bus | output | 1 | Bus select of the run |
| mem_prio | output | 2 | Priority of the run |
| mem_wdata | output | 32 | Write data (head of FIFO) |
| mem_ack | input | 1 | Beat accepted |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| active | output | 1 | Channel open |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | Descriptor completion pulse |

## Verification
The bench runs pairs longer than the FIFO (25 and 20 beats). An engine that ignored the full condition would overrun and lose words, and one that put writes first would start writing too early, so both the beat number of the first write and the full data order are checked. It also withholds acknowledges on two cycles out of three, which catches an engine that moves its address or switches between read and write while a request is waiting. A two-pair chain, with the interrupt enabled on the first read and on the last write, catches a design that stops after one pair, raises its interrupt only at channel close, or pulses for descriptors that do not enable it. Control writes made while the engine runs, or without the activate bit, must leave the transfer unchanged.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

    localparam int IDX_W = 4;

    typedef struct packed {
        logic             vnext;
        logic [IDX_W-1:0] nxt;
        logic             irq_en;
        logic [1:0]       size;
    } attr_t;

    localparam int ATTR_W = $bits(attr_t);

    typedef enum logic {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } seq_st_e;

    // Bytes moved per beat for a size code.
    function automatic logic [2:0] beat_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    beat_bytes = 3'd1;
            2'd1:    beat_bytes = 3'd2;
            default: beat_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_desc_table.sv
module dma_desc_table
    import dma_chain_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [CNT_W-1:0]  wcnt,
    input  attr_t             wattr,
    input  logic [IDX_W-1:0]  ridx_a,
    output logic [ADDR_W-1:0] raddr_a,
    output logic [CNT_W-1:0]  rcnt_a,
    output attr_t             rattr_a,
    input  logic [IDX_W-1:0]  ridx_b,
    output logic [ADDR_W-1:0] raddr_b,
    output logic [CNT_W-1:0]  rcnt_b,
    output attr_t             rattr_b
);

    localparam int DEPTH = 1 << IDX_W;

    logic [ADDR_W-1:0] addr_d [DEPTH];
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [CNT_W-1:0]  cnt_d  [DEPTH];
    logic [CNT_W-1:0]  cnt_q  [DEPTH];
    attr_t             attr_d [DEPTH];
    attr_t             attr_q [DEPTH];

    always_comb begin
        addr_d = addr_q;
        cnt_d  = cnt_q;
        attr_d = attr_q;
        if (we) begin
            addr_d[widx] = waddr;
            cnt_d[widx]  = wcnt;
            attr_d[widx] = wattr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                addr_q[i] <= '0;
                cnt_q[i]  <= '0;
                attr_q[i] <= '0;
            end
        end else begin
            addr_q <= addr_d;
            cnt_q  <= cnt_d;
            attr_q <= attr_d;
        end
    end

    assign raddr_a = addr_q[ridx_a];
    assign rcnt_a  = cnt_q[ridx_a];
    assign rattr_a = attr_q[ridx_a];
    assign raddr_b = addr_q[ridx_b];
    assign rcnt_b  = cnt_q[ridx_b];
    assign rattr_b = attr_q[ridx_b];

endmodule

// File: rtl/dma_fifo.sv
module dma_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic              full,
    output logic              empty
);

    localparam int PW = $clog2(DEPTH);

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [PW:0]   cnt;
    } fifo_t;

    fifo_t             f_d, f_q;
    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        f_d   = f_q;
        mem_d = mem_q;
        if (push) begin
            mem_d[f_q.wp] = wdata;
            f_d.wp        = f_q.wp + 1'b1;
        end
        if (pop) begin
            f_d.rp = f_q.rp + 1'b1;
        end
        if (push && !pop) f_d.cnt = f_q.cnt + 1'b1;
        if (pop && !push) f_d.cnt = f_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            f_q   <= f_d;
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[f_q.rp];
    assign full  = (f_q.cnt == (PW+1)'(DEPTH));
    assign empty = (f_q.cnt == '0);

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_chain_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              ctl_act,
    input  logic              ctl_bus,
    input  logic [1:0]        ctl_prio,
    input  logic [IDX_W-1:0]  ctl_first,
    input  logic              done_clr,
    output logic [IDX_W-1:0]  tidx_a,
    input  logic [ADDR_W-1:0] taddr_a,
    input  logic [CNT_W-1:0]  tcnt_a,
    input  attr_t             tattr_a,
    output logic [IDX_W-1:0]  tidx_b,
    input  logic [ADDR_W-1:0] taddr_b,
    input  logic [CNT_W-1:0]  tcnt_b,
    input  attr_t             tattr_b,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    output logic              fifo_push,
    output logic              fifo_pop,
    output logic              mem_req,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic              mem_bus,
    output logic [1:0]        mem_prio,
    input  logic              mem_ack,
    output logic              active,
    output logic              done,
    output logic              irq
);

    typedef struct packed {
        seq_st_e           st;
        logic [ADDR_W-1:0] r_addr;
        logic [ADDR_W-1:0] w_addr;
        logic [CNT_W-1:0]  r_cnt;
        logic [CNT_W-1:0]  w_cnt;
        attr_t             r_attr;
        attr_t             w_attr;
        logic              bus;
        logic [1:0]        prio;
        logic              done;
        logic              irq;
    } seq_t;

    seq_t        s_d, s_q;
    logic        rd_go, wr_go, load_pair;
    logic [CNT_W-1:0] r_step, w_step;

    always_comb begin
        tidx_a = (s_q.st == S_IDLE) ? ctl_first : s_q.w_attr.nxt;
        tidx_b = tattr_a.nxt;

        rd_go = (s_q.st == S_RUN) && (s_q.r_cnt != '0) && !fifo_full;
        wr_go = (s_q.st == S_RUN) && !rd_go && (s_q.w_cnt != '0) && !fifo_empty;

        r_step = CNT_W'(beat_bytes(s_q.r_attr.size));
        w_step = CNT_W'(beat_bytes(s_q.w_attr.size));

        fifo_push = rd_go && mem_ack;
        fifo_pop  = wr_go && mem_ack;
        load_pair = 1'b0;

        s_d     = s_q;
        s_d.irq = 1'b0;
        if (done_clr) s_d.done = 1'b0;

        case (s_q.st)
            S_IDLE: begin
                if (ctl_we && ctl_act) begin
                    load_pair = 1'b1;
                    s_d.st    = S_RUN;
                    s_d.bus   = ctl_bus;
                    s_d.prio  = ctl_prio;
                end
            end
            default: begin
                if (fifo_push) begin
                    s_d.r_addr = s_q.r_addr + ADDR_W'(r_step);
                    s_d.r_cnt  = s_q.r_cnt - r_step;
                    if (s_q.r_cnt == r_step && s_q.r_attr.irq_en) s_d.irq = 1'b1;
                end
                if (fifo_pop) begin
                    s_d.w_addr = s_q.w_addr + ADDR_W'(w_step);
                    s_d.w_cnt  = s_q.w_cnt - w_step;
                    if (s_q.w_cnt == w_step && s_q.w_attr.irq_en) s_d.irq = 1'b1;
                end
                if (s_q.r_cnt == '0 && s_q.w_cnt == '0) begin
                    if (s_q.w_attr.vnext) begin
                        load_pair = 1'b1;
                    end else begin
                        s_d.st   = S_IDLE;
                        s_d.done = 1'b1;
                    end
                end
            end
        endcase

        if (load_pair) begin
            s_d.r_addr = taddr_a;
            s_d.r_cnt  = tcnt_a;
            s_d.r_attr = tattr_a;
            s_d.w_addr = taddr_b;
            s_d.w_cnt  = tcnt_b;
            s_d.w_attr = tattr_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= S_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_req  = rd_go || wr_go;
    assign mem_wr   = wr_go;
    assign mem_addr = wr_go ? s_q.w_addr : s_q.r_addr;
    assign mem_size = wr_go ? s_q.w_attr.size : s_q.r_attr.size;
    assign mem_bus  = s_q.bus;
    assign mem_prio = s_q.prio;
    assign active   = (s_q.st == S_RUN);
    assign done     = s_q.done;
    assign irq      = s_q.irq;

endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
    import dma_chain_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int FIFO_N = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_idx,
    input  logic [ADDR_W-1:0] tbl_addr,
    input  logic [CNT_W-1:0]  tbl_count,
    input  logic [ATTR_W-1:0] tbl_attr,
    input  logic              ctl_we,
    input  logic              ctl_act,
    input  logic              ctl_bus,
    input  logic [1:0]        ctl_prio,
    input  logic [IDX_W-1:0]  ctl_first,
    input  logic              done_clr,
    output logic              mem_req,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic              mem_bus,
    output logic [1:0]        mem_prio,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              active,
    output logic              done,
    output logic              irq
);

    logic [IDX_W-1:0]  idx_a, idx_b;
    logic [ADDR_W-1:0] addr_a, addr_b;
    logic [CNT_W-1:0]  cnt_a, cnt_b;
    attr_t             attr_a, attr_b;
    logic              f_push, f_pop, f_full, f_empty;

    dma_desc_table #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (tbl_we),
        .widx    (tbl_idx),
        .waddr   (tbl_addr),
        .wcnt    (tbl_count),
        .wattr   (attr_t'(tbl_attr)),
        .ridx_a  (idx_a),
        .raddr_a (addr_a),
        .rcnt_a  (cnt_a),
        .rattr_a (attr_a),
        .ridx_b  (idx_b),
        .raddr_b (addr_b),
        .rcnt_b  (cnt_b),
        .rattr_b (attr_b)
    );

    dma_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_N)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (f_push),
        .wdata (mem_rdata),
        .pop   (f_pop),
        .rdata (mem_wdata),
        .full  (f_full),
        .empty (f_empty)
    );

    dma_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_we     (ctl_we),
        .ctl_act    (ctl_act),
        .ctl_bus    (ctl_bus),
        .ctl_prio   (ctl_prio),
        .ctl_first  (ctl_first),
        .done_clr   (done_clr),
        .tidx_a     (idx_a),
        .taddr_a    (addr_a),
        .tcnt_a     (cnt_a),
        .tattr_a    (attr_a),
        .tidx_b     (idx_b),
        .taddr_b    (addr_b),
        .tcnt_b     (cnt_b),
        .tattr_b    (attr_b),
        .fifo_full  (f_full),
        .fifo_empty (f_empty),
        .fifo_push  (f_push),
        .fifo_pop   (f_pop),
        .mem_req    (mem_req),
        .mem_wr     (mem_wr),
        .mem_addr   (mem_addr),
        .mem_size   (mem_size),
        .mem_bus    (mem_bus),
        .mem_prio   (mem_prio),
        .mem_ack    (mem_ack),
        .active     (active),
        .done       (done),
        .irq        (irq)
    );

endmodule

// File: rtl/dma_chain_engine_chk.sv
module dma_chain_engine_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_we,
    input logic              ctl_act,
    input logic              done_clr,
    input logic              mem_req,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              active,
    input logic              done,
    input logic              irq
);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !mem_req);

    p_start_needs_act_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(ctl_we && ctl_act));

    p_req_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wr)));

    p_stop_sets_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> done);

    p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_clr) |=> done);

    p_irq_after_beat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(mem_req && mem_ack));

endmodule

bind dma_chain_engine dma_chain_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_we   (ctl_we),
    .ctl_act  (ctl_act),
    .done_clr (done_clr),
    .mem_req  (mem_req),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .active   (active),
    .done     (done),
    .irq      (irq)
);

// File: tb/dma_chain_engine_bench.sv
`timescale 1ns/1ps
module dma_chain_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [3:0]  tbl_idx = '0;
    logic [31:0] tbl_addr = '0;
    logic [15:0] tbl_count = '0;
    logic [7:0]  tbl_attr = '0;
    logic        ctl_we = 1'b0;
    logic        ctl_act = 1'b0;
    logic        ctl_bus = 1'b0;
    logic [1:0]  ctl_prio = '0;
    logic [3:0]  ctl_first = '0;
    logic        done_clr = 1'b0;
    logic        mem_req, mem_wr, mem_bus, active, done, irq;
    logic [31:0] mem_addr, mem_wdata;
    logic [1:0]  mem_size, mem_prio;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    dma_chain_engine u_dma_chain_engine (
        .clk(clk), .rst_n(rst_n),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_addr(tbl_addr),
        .tbl_count(tbl_count), .tbl_attr(tbl_attr),
        .ctl_we(ctl_we), .ctl_act(ctl_act), .ctl_bus(ctl_bus),
        .ctl_prio(ctl_prio), .ctl_first(ctl_first), .done_clr(done_clr),
        .mem_req(mem_req), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_bus(mem_bus), .mem_prio(mem_prio),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .active(active), .done(done), .irq(irq)
    );

    // Stimulus vectors: one read/write pair each (read desc 2 -> write desc 8).
    localparam int NV = 4;
    localparam logic [31:0] V_SRC   [NV] = '{32'h2000_0300, 32'h0000_1000, 32'h4000_0010, 32'h0000_0030};
    localparam logic [31:0] V_DST   [NV] = '{32'h0200_4000, 32'h0000_8000, 32'h4000_1000, 32'h0000_0090};
    localparam logic [15:0] V_CNT   [NV] = '{16'd100, 16'd5, 16'd6, 16'd80};
    localparam logic [1:0]  V_SIZE  [NV] = '{2'd2, 2'd0, 2'd1, 2'd3};
    localparam logic [1:0]  V_PRIO  [NV] = '{2'd1, 2'd3, 2'd2, 2'd0};
    localparam logic        V_BUS   [NV] = '{1'b0, 1'b1, 1'b1, 1'b0};
    localparam int          V_SLOW  [NV] = '{0, 1, 0, 1};
    localparam int          V_BEATS [NV] = '{25, 5, 3, 20};

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // Memory responder and monitor (sole writer of its counters and logs).
    int          ack_mode = 0;
    logic [1:0]  exp_size = '0;
    logic        exp_bus = 1'b0;
    logic [1:0]  exp_prio = '0;
    int          cyc = 0;
    int          n_rd = 0, n_wr = 0, n_beat = 0, n_irq = 0, attr_err = 0;
    logic [31:0] rd_addr_log [256];
    logic [31:0] wr_addr_log [256];
    logic [31:0] wr_data_log [256];
    int          wr_beat_log [256];

    function automatic logic [31:0] pat(input logic [31:0] a);
        return a ^ 32'h5A5A_C3C3;
    endfunction

    function automatic int bytes_of(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (irq) n_irq = n_irq + 1;
        if (rst_n && mem_req && (ack_mode == 0 || cyc % 3 == 0)) begin
            mem_ack   <= 1'b1;
            mem_rdata <= pat(mem_addr);
            if (mem_size != exp_size || mem_bus != exp_bus || mem_prio != exp_prio)
                attr_err = attr_err + 1;
            if (mem_wr) begin
                wr_addr_log[n_wr % 256] = mem_addr;
                wr_data_log[n_wr % 256] = mem_wdata;
                wr_beat_log[n_wr % 256] = n_beat;
                n_wr = n_wr + 1;
            end else begin
                rd_addr_log[n_rd % 256] = mem_addr;
                n_rd = n_rd + 1;
            end
            n_beat = n_beat + 1;
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_desc(input logic [3:0] idx, input logic [31:0] a,
                            input logic [15:0] c, input logic [7:0] at);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = idx; tbl_addr = a; tbl_count = c; tbl_attr = at;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic ctl_write(input logic act, input logic [3:0] first,
                             input logic bus, input logic [1:0] prio);
        @(negedge clk);
        ctl_we = 1'b1; ctl_act = act; ctl_first = first; ctl_bus = bus; ctl_prio = prio;
        @(negedge clk);
        ctl_we = 1'b0; ctl_act = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int t = 0;
        while (!done && t < 3000) begin
            @(negedge clk);
            t++;
        end
        if (!done) chk({req, " watchdog on done"}, 32'd0, 32'd1);
    endtask

    int rb, wb, bb, ib, ab;
    task automatic snap();
        rb = n_rd; wb = n_wr; bb = n_beat; ib = n_irq; ab = attr_err;
    endtask

    // Checks one pair starting at log offsets (ro, wo) for n beats.
    task automatic chk_pair(input string req, input int ro, input int wo, input int n,
                            input logic [31:0] src, input logic [31:0] dst, input int by);
        int ea = 0, ew = 0;
        for (int k = 0; k < n; k++) begin
            if (rd_addr_log[(ro + k) % 256] !== src + 32'(k * by)) ea++;
            if (wr_addr_log[(wo + k) % 256] !== dst + 32'(k * by)) ew++;
            if (wr_data_log[(wo + k) % 256] !== pat(src + 32'(k * by))) ew++;
        end
        chk({req, " R5 read address sequence errors"}, 32'(ea), 32'd0);
        chk({req, " R6 write address/data order errors"}, 32'(ew), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 active after reset", 32'(active), 32'd0);
        chk("R1 done after reset", 32'(done), 32'd0);
        chk("R1 irq after reset", 32'(irq), 32'd0);
        chk("R1 mem_req after reset", 32'(mem_req), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3: control write without the activate bit does not start
        set_desc(4'd2, 32'h100, 16'd8, {1'b0, 4'd8, 1'b0, 2'd2});
        set_desc(4'd8, 32'h200, 16'd8, {1'b0, 4'd0, 1'b1, 2'd2});
        snap();
        ctl_write(1'b0, 4'd2, 1'b0, 2'd0);
        repeat (6) @(negedge clk);
        chk("R3 no start without activate", 32'(active), 32'd0);
        chk("R3 no beats without activate", 32'(n_beat - bb), 32'd0);

        // Vector table walk (R2 R4 R5 R6 R7 R8 R10 R11)
        for (int i = 0; i < NV; i++) begin
            int by;
            int fw;
            by = bytes_of(V_SIZE[i]);
            set_desc(4'd2, V_SRC[i], V_CNT[i], {1'b0, 4'd8, 1'b0, V_SIZE[i]});
            set_desc(4'd8, V_DST[i], V_CNT[i], {1'b0, 4'd0, 1'b1, V_SIZE[i]});
            ack_mode = V_SLOW[i];
            exp_size = V_SIZE[i]; exp_bus = V_BUS[i]; exp_prio = V_PRIO[i];
            snap();
            ctl_write(1'b1, 4'd2, V_BUS[i], V_PRIO[i]);
            wait_done("R10");
            @(negedge clk);
            chk($sformatf("R5 vec%0d read beats", i), 32'(n_rd - rb), 32'(V_BEATS[i]));
            chk($sformatf("R4 vec%0d write beats via read next", i), 32'(n_wr - wb), 32'(V_BEATS[i]));
            chk_pair($sformatf("vec%0d", i), rb, wb, V_BEATS[i], V_SRC[i], V_DST[i], by);
            chk($sformatf("R5 R8 vec%0d size/bus/prio errors", i), 32'(attr_err - ab), 32'd0);
            fw = (V_BEATS[i] < 16) ? V_BEATS[i] : 16;
            chk($sformatf("R7 vec%0d first write beat", i), 32'(wr_beat_log[wb % 256] - bb), 32'(fw));
            chk($sformatf("R10 vec%0d active after finish", i), 32'(active), 32'd0);
            chk($sformatf("R11 vec%0d irq pulses", i), 32'(n_irq - ib), 32'd1);
            repeat (8) @(negedge clk);
            chk($sformatf("R10 vec%0d done sticky", i), 32'(done), 32'd1);
            pulse_clr();
            chk($sformatf("R10 vec%0d done cleared", i), 32'(done), 32'd0);
        end

        // R9 chain of two pairs; irq enabled on first read and last write (R11)
        ack_mode = 0;
        exp_size = 2'd2; exp_bus = 1'b1; exp_prio = 2'd2;
        set_desc(4'd0, 32'h0000_0100, 16'd8, {1'b0, 4'd1, 1'b1, 2'd2});
        set_desc(4'd1, 32'h0000_0900, 16'd8, {1'b1, 4'd5, 1'b0, 2'd2});
        set_desc(4'd5, 32'h0000_0300, 16'd8, {1'b0, 4'd6, 1'b0, 2'd2});
        set_desc(4'd6, 32'h0000_0B00, 16'd8, {1'b0, 4'd0, 1'b1, 2'd2});
        snap();
        ctl_write(1'b1, 4'd0, 1'b1, 2'd2);
        wait_done("R9");
        @(negedge clk);
        chk("R9 chained read beats", 32'(n_rd - rb), 32'd4);
        chk("R9 chained write beats", 32'(n_wr - wb), 32'd4);
        chk_pair("R9 R2 pair1", rb, wb, 2, 32'h100, 32'h900, 4);
        chk_pair("R9 R2 pair2", rb + 2, wb + 2, 2, 32'h300, 32'hB00, 4);
        chk("R11 irq pulses per enabled descriptor", 32'(n_irq - ib), 32'd2);
        chk("R10 chain closes channel", 32'(active), 32'd0);
        pulse_clr();

        // R3 control write during a run is ignored
        set_desc(4'd2, 32'h2000_0300, 16'd100, {1'b0, 4'd8, 1'b0, 2'd2});
        set_desc(4'd8, 32'h0200_4000, 16'd100, {1'b0, 4'd0, 1'b1, 2'd2});
        exp_size = 2'd2; exp_bus = 1'b0; exp_prio = 2'd1;
        snap();
        ctl_write(1'b1, 4'd2, 1'b0, 2'd1);
        repeat (3) @(negedge clk);
        ctl_write(1'b1, 4'd5, 1'b1, 2'd3);
        wait_done("R3");
        @(negedge clk);
        chk("R3 busy write: read beats unchanged", 32'(n_rd - rb), 32'd25);
        chk("R3 busy write: write beats unchanged", 32'(n_wr - wb), 32'd25);
        chk("R3 busy write: bus/prio unchanged", 32'(attr_err - ab), 32'd0);
        chk_pair("R3 busy", rb, wb, 25, 32'h2000_0300, 32'h0200_4000, 4);

        // R10 set wins over a same-edge clear is not reachable from idle; check clear when idle
        pulse_clr();
        chk("R10 done clear", 32'(done), 32'd0);
        chk("R1 idle no request", 32'(mem_req), 32'd0);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule